// File: doc/BRIEF.md
# Byte Check-Bit Generator with Scannable Parity Flag

This block takes one 8-bit data byte and computes five parity values from it. Four are modified Hamming check bits, each taken over a fixed group of four data bits. The fifth is the parity of the whole byte. These outputs are purely combinational. A system uses them as the check field that goes with each byte of a protected word. The syndrome decoding and the bit correction are done by other logic.

A second path starts from the whole-byte parity. A select input can invert it to change between even and odd sense. An incoming byte-parity bit is then XORed in, so a byte and parity bit that agree give a zero. The result is the generated-parity output. It feeds a one-bit flag register. That register can capture it, or it can take a serial scan input instead, which lets it sit in a scan chain. The register has hold and enable controls. Its value is given in true and complement form.

The register's next-state choice is modelled as four named actions:

- **IDLE**: enable is low, so the register keeps its value.
- **HOLD**: hold is high, so the register keeps its value whatever enable and shift are.
- **CAPTURE**: the register loads the generated parity.
- **SCAN**: the register loads the serial input.

A synchronous reset moves the register to 0 from any action.

Top module: `hamming_scan_parity`

## Requirements
- R1: `chk_out[0]` equals the XOR of data bits 1, 3, 5 and 7 at all times (data bit n is `data_in[n]`).
- R2: `chk_out[1]` equals the XOR of data bits 2, 3, 6 and 7.
- R3: `chk_out[2]` equals the XOR of data bits 4, 5, 6 and 7.
- R4: `chk_out[3]` equals the XOR of data bits 1, 2, 4 and 7.
- R5: `word_par` is 1 exactly when `data_in` has an odd number of ones.
- R6: `gen_par` equals `word_par` XOR `odd_sel` XOR `bpar_in`, combinationally. Setting `odd_sel` = 1 inverts it.
- R7: With `rst` high at a rising clock edge, `err_q` becomes 0 after that edge and `err_qn` becomes 1, whatever the other inputs are.
- R8: With `hold` high and `rst` low, `err_q` keeps its value across the edge, whatever `enable`, `shift`, `scan_in` and the data are.
- R9: With `hold` low, `enable` high and `shift` low, `err_q` takes the value `gen_par` had before the edge.
- R10: With `hold` low, `enable` high and `shift` high, `err_q` takes the value `scan_in` had before the edge.
- R11: With `hold` low and `enable` low, `err_q` keeps its value.
- R12: `err_qn` is always the complement of `err_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data byte |
| odd_sel | input | 1 | 1 selects odd sense (inverts the parity) |
| bpar_in | input | 1 | Incoming byte-parity bit |
| hold | input | 1 | Freeze the flag register; takes priority over enable |
| enable | input | 1 | Allow the flag register to load |
| shift | input | 1 | 1 loads scan_in, 0 loads gen_par |
| scan_in | input | 1 | Serial scan input |
| chk_out | output | 4 | Check bits, with index 0..3 as in R1..R4 |
| word_par | output | 1 | Parity of the whole byte |
| gen_par | output | 1 | Gated generated parity |
| err_q | output | 1 | Flag register, true form |
| err_qn | output | 1 | Flag register, complement form |

## Verification
The check-bit equations are exercised with several byte patterns:

- **All-zeros and all-ones bytes** test the parity of the full group.
- **A walking one** shows which data bits feed each check bit. This separates the nonstandard fourth group from an ordinary Hamming group.
- **Random bytes** catch swapped or missing terms.

All four combinations of `odd_sel` and `bpar_in` are tried, to tell apart an inversion from a missing gate.

For the flag register, random hold, enable and shift settings are applied with scan and parity values that differ. This shows which source was loaded, and that hold wins over enable.

// File: rtl/hamming_scan_parity_pkg.sv
package hamming_scan_parity_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_CHK = 4;

    // Next-state action of the flag register
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_HOLD    = 2'd1,
        ACT_CAPTURE = 2'd2,
        ACT_SCAN    = 2'd3
    } reg_act_e;

    // Data bits that feed check bit idx.
    // Index 3 is the nonstandard mixed group.
    function automatic logic [DATA_W-1:0] chk_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            unique case (idx)
                0: m[b] = b[0];
                1: m[b] = b[1];
                2: m[b] = b[2];
                default: m[b] = (b == 1) || (b == 2) || (b == 4) || (b == 7);
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/hsp_checkbits.sv
module hsp_checkbits
    import hamming_scan_parity_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int C = NUM_CHK
) (
    input  logic [W-1:0] data,
    output logic [C-1:0] chk,
    output logic         par_all
);

    // One reduction per check bit over its masked group
    for (genvar g = 0; g < C; g++) begin : g_chk
        localparam logic [W-1:0] MASK = chk_mask(g);
        assign chk[g] = ^(data & MASK);
    end

    assign par_all = ^data;

endmodule

// File: rtl/hsp_pargate.sv
module hsp_pargate (
    input  logic par_all,
    input  logic odd_sel,
    input  logic bpar,
    output logic gen
);

    logic sensed;

    always_comb begin
        sensed = odd_sel ? ~par_all : par_all;
        gen    = sensed ^ bpar;
    end

endmodule

// File: rtl/hsp_scanreg.sv
module hsp_scanreg
    import hamming_scan_parity_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic enable,
    input  logic shift,
    input  logic par_d,
    input  logic scan_d,
    output logic q,
    output logic qn
);

    reg_act_e act;
    logic     q_nxt;
    logic     q_r;

    // Action decode: hold beats enable
    always_comb begin
        if (hold)        act = ACT_HOLD;
        else if (!enable) act = ACT_IDLE;
        else if (shift)  act = ACT_SCAN;
        else             act = ACT_CAPTURE;
    end

    always_comb begin
        unique case (act)
            ACT_IDLE:    q_nxt = q_r;
            ACT_HOLD:    q_nxt = q_r;
            ACT_CAPTURE: q_nxt = par_d;
            ACT_SCAN:    q_nxt = scan_d;
            default:     q_nxt = q_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= q_nxt;
    end

    always_comb begin
        q  = q_r;
        qn = ~q_r;
    end

endmodule

// File: rtl/hamming_scan_parity.sv
module hamming_scan_parity
    import hamming_scan_parity_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              odd_sel,
    input  logic              bpar_in,
    input  logic              hold,
    input  logic              enable,
    input  logic              shift,
    input  logic              scan_in,
    output logic [NUM_CHK-1:0] chk_out,
    output logic              word_par,
    output logic              gen_par,
    output logic              err_q,
    output logic              err_qn
);

    hsp_checkbits #(.W(DATA_W), .C(NUM_CHK)) u_chk (
        .data    (data_in),
        .chk     (chk_out),
        .par_all (word_par)
    );

    hsp_pargate u_gate (
        .par_all (word_par),
        .odd_sel (odd_sel),
        .bpar    (bpar_in),
        .gen     (gen_par)
    );

    hsp_scanreg u_reg (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .enable (enable),
        .shift  (shift),
        .par_d  (gen_par),
        .scan_d (scan_in),
        .q      (err_q),
        .qn     (err_qn)
    );

endmodule

// File: rtl/hamming_scan_parity_chk.sv
module hamming_scan_parity_chk (
    input logic clk,
    input logic rst,
    input logic hold,
    input logic enable,
    input logic shift,
    input logic scan_in,
    input logic gen_par,
    input logic err_q,
    input logic err_qn
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!err_q && err_qn)); // R7
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(err_q)); // R8
    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst) (!hold && enable && !shift) |=> (err_q == $past(gen_par))); // R9
    AST_SCAN_LOADS: assert property (@(posedge clk) disable iff (rst) (!hold && enable && shift) |=> (err_q == $past(scan_in))); // R10
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst) (!hold && !enable) |=> $stable(err_q)); // R11
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) (err_qn == ~err_q)); // R12

endmodule

bind hamming_scan_parity hamming_scan_parity_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .enable  (enable),
    .shift   (shift),
    .scan_in (scan_in),
    .gen_par (gen_par),
    .err_q   (err_q),
    .err_qn  (err_qn)
);

// File: tb/hamming_scan_parity_tb_top.sv
`timescale 1ns/1ps
module hamming_scan_parity_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] data_in;
    logic       odd_sel, bpar_in, hold, enable, shift, scan_in;
    logic [3:0] chk_out;
    logic       word_par, gen_par, err_q, err_qn;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic model_q;

    always #2.5 clk = ~clk;

    hamming_scan_parity dut_i (
        .clk(clk), .rst(rst), .data_in(data_in), .odd_sel(odd_sel),
        .bpar_in(bpar_in), .hold(hold), .enable(enable), .shift(shift),
        .scan_in(scan_in), .chk_out(chk_out), .word_par(word_par),
        .gen_par(gen_par), .err_q(err_q), .err_qn(err_qn)
    );

    function automatic logic [3:0] exp_chk(input logic [7:0] d);
        logic [3:0] r;
        r[0] = d[1] ^ d[3] ^ d[5] ^ d[7];
        r[1] = d[2] ^ d[3] ^ d[6] ^ d[7];
        r[2] = d[4] ^ d[5] ^ d[6] ^ d[7];
        r[3] = d[1] ^ d[2] ^ d[4] ^ d[7];
        return r;
    endfunction

    function automatic logic exp_par(input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        return logic'(ones % 2);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_comb();
        logic [3:0] c;
        logic       wp;
        logic       gp;
        #1;
        c  = exp_chk(data_in);
        wp = exp_par(data_in);
        gp = wp ^ odd_sel ^ bpar_in;
        check("R1", {7'd0, chk_out[0]}, {7'd0, c[0]});
        check("R2", {7'd0, chk_out[1]}, {7'd0, c[1]});
        check("R3", {7'd0, chk_out[2]}, {7'd0, c[2]});
        check("R4", {7'd0, chk_out[3]}, {7'd0, c[3]});
        check("R5", {7'd0, word_par}, {7'd0, wp});
        check("R6", {7'd0, gen_par}, {7'd0, gp});
    endtask

    // Inputs are set at negedge; the model predicts the next state,
    // the edge fires, and the outputs are sampled 1 ns later.
    task automatic clock_step(input string req);
        logic gp;
        gp = exp_par(data_in) ^ odd_sel ^ bpar_in;
        if (rst)          model_q = 1'b0;
        else if (hold)    model_q = model_q;
        else if (enable)  model_q = shift ? scan_in : gp;
        @(posedge clk);
        #1;
        check(req, {7'd0, err_q}, {7'd0, model_q});
        check("R12", {7'd0, err_qn}, {7'd0, ~model_q});
        @(negedge clk);
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; data_in = 8'hFF; odd_sel = 1'b1; bpar_in = 1'b0;
        hold = 1'b0; enable = 1'b1; shift = 1'b0; scan_in = 1'b1;
        model_q = 1'b0;
        @(negedge clk);
        clock_step("R7");
        clock_step("R7");
        rst = 1'b0;

        // Directed combinational patterns
        data_in = 8'h00;
        for (int k = 0; k < 4; k++) begin
            {odd_sel, bpar_in} = 2'(k);
            check_comb();
        end
        data_in = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            {odd_sel, bpar_in} = 2'(k);
            check_comb();
        end
        for (int b = 0; b < 8; b++) begin
            data_in = 8'(1 << b);
            check_comb();
        end
        @(negedge clk);

        // Directed register cases
        hold = 1'b0; enable = 1'b1; shift = 1'b1; scan_in = 1'b1;
        clock_step("R10");
        hold = 1'b1; scan_in = 1'b0; shift = 1'b1; enable = 1'b1;
        clock_step("R8");
        hold = 1'b0; enable = 1'b0; scan_in = 1'b0;
        clock_step("R11");
        enable = 1'b1; shift = 1'b0; data_in = 8'h01; odd_sel = 1'b0; bpar_in = 1'b1;
        clock_step("R9");
        data_in = 8'h07; bpar_in = 1'b0;
        clock_step("R9");
        rst = 1'b1; hold = 1'b1;
        clock_step("R7");
        rst = 1'b0; hold = 1'b0;

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            data_in = 8'($urandom);
            odd_sel = 1'($urandom);
            bpar_in = 1'($urandom);
            scan_in = 1'($urandom);
            shift   = 1'($urandom);
            hold    = ($urandom % 4) == 0;
            enable  = ($urandom % 4) != 0;
            rst     = ($urandom % 50) == 0;
            check_comb();
            if (rst)        clock_step("R7");
            else if (hold)  clock_step("R8");
            else if (!enable) clock_step("R11");
            else if (shift) clock_step("R10");
            else            clock_step("R9");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule